// File: doc/BRIEF.md
# Diagnostic Output Selector

This block picks which internal 16-bit words go to three diagnostic outputs: two auxiliary DAC channels and a 16-bit logic-analyzer port. A 16-bit control word holds one 4-bit selector field for each output. The candidate words are the Filter 1 bandwidth curve, the Filter 2 bandwidth curve, a test word and the digitized phase-detector ADC sample. The logic-analyzer port can also show a bit-status word. DAC words use offset binary coding, so 0x0000 is negative full scale, 0x8000 is zero and 0xFFFF is positive full scale.

All outputs are refreshed together on a fixed update boundary. By default this boundary comes once every 128 clocks, which gives a 1.6 us DAC update period from an 80 MHz clock. Each DAC output has a one-clock load strobe that marks a fresh word. The logic-analyzer word is qualified by a one-clock data strobe that comes one clock later. Selector codes and source words are sampled only at the boundary, so an output word never mixes two sources.

Top module: `diag_route_top`

## Requirements
- R1: While reset is held, both DAC words read 0x8000, both DAC load strobes are low, the logic-analyzer word reads 0x0000 and its strobe is low.
- R2: Control bits [3:0] choose the DAC 1 word: code 0 gives the Filter 1 curve, code 1 the Filter 2 curve, code 2 the test word, and code 3 or code 4 the ADC sample.
- R3: Control bits [7:4] choose the DAC 2 word, using the same code map as R2.
- R4: A DAC selector code from 5 to 15 drives that DAC word to 0x8000 (zero volts).
- R5: Control bits [11:8] choose the logic-analyzer word: code 1 or code 2 gives the ADC sample, code 3 the Filter 1 curve, code 4 the Filter 2 curve, and code 5 the bit-status word.
- R6: A logic-analyzer code of 0 or of 6 to 15 drives the logic-analyzer word to 0x0000 and gives no data strobe at that boundary.
- R7: The load strobes of both DACs are high together for exactly one clock after each update boundary. Boundaries come every 128 clocks. The first strobe is high in the cycle that follows the 128th rising edge after reset is released.
- R8: When the logic-analyzer code is valid, the data strobe is high for exactly one clock. That clock comes one clock after the logic-analyzer word is refreshed, which is the cycle after the DAC load strobe.
- R9: A change of the control word or of any source word between two boundaries leaves every output word unchanged until the next boundary. At that boundary the change takes effect.
- R10: Control bits [15:12] have no effect on any routed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_reg | input | 16 | Diagnostic control word with the selector fields |
| filt1_word | input | 16 | Filter 1 bandwidth curve sample |
| filt2_word | input | 16 | Filter 2 bandwidth curve sample |
| test_word | input | 16 | Test register value |
| adc_word | input | 16 | Digitized phase-detector sample |
| status_word | input | 16 | Bit-status word |
| dac1_word | output | 16 | DAC 1 word, offset binary |
| dac2_word | output | 16 | DAC 2 word, offset binary |
| dac1_load | output | 1 | DAC 1 load strobe |
| dac2_load | output | 1 | DAC 2 load strobe |
| la_word | output | 16 | Logic-analyzer data word |
| la_strobe | output | 1 | Logic-analyzer data strobe |

## Verification
The hardest case to reach from the ports is a selector or source change that lands strictly between two update boundaries. Outputs that moved at once would look correct unless they are sampled before the next boundary. The stimulus first lines up on an observed load strobe. It then changes the control word and a source word a few clocks later and samples every output word well before the next boundary. After that it waits for the boundary and checks that the new values appear.

// File: rtl/diag_route_pkg.sv
package diag_route_pkg;
  localparam int WORD_W  = 16;
  localparam int SEL_W   = 4;
  localparam int NUM_DAC = 2;
  localparam logic [WORD_W-1:0] DAC_MID = {1'b1, {(WORD_W-1){1'b0}}};

  typedef logic [SEL_W-1:0] sel_t;

  typedef struct packed {
    logic [WORD_W-1:0] f1;
    logic [WORD_W-1:0] f2;
    logic [WORD_W-1:0] tst;
    logic [WORD_W-1:0] adc;
    logic [WORD_W-1:0] stat;
  } diag_src_t;

  function automatic logic [WORD_W-1:0] dac_pick(sel_t c, diag_src_t s);
    case (c)
      4'd0:       return s.f1;
      4'd1:       return s.f2;
      4'd2:       return s.tst;
      4'd3, 4'd4: return s.adc;
      default:    return DAC_MID;
    endcase
  endfunction

  function automatic logic la_live(sel_t c);
    return (c >= 4'd1) && (c <= 4'd5);
  endfunction

  function automatic logic [WORD_W-1:0] la_pick(sel_t c, diag_src_t s);
    case (c)
      4'd1, 4'd2: return s.adc;
      4'd3:       return s.f1;
      4'd4:       return s.f2;
      4'd5:       return s.stat;
      default:    return '0;
    endcase
  endfunction
endpackage

// File: rtl/diag_pacer.sv
module diag_pacer #(
  parameter int PERIOD = 128
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/diag_dac_lane.sv
module diag_dac_lane
  import diag_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  sel_t              code,
  input  diag_src_t         srcs,
  output logic [WORD_W-1:0] word,
  output logic              load
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word <= DAC_MID;
      load <= 1'b0;
    end else begin
      load <= upd;
      if (upd) word <= dac_pick(code, srcs);
    end
  end
endmodule

// File: rtl/diag_la_lane.sv
module diag_la_lane
  import diag_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  sel_t              code,
  input  diag_src_t         srcs,
  output logic [WORD_W-1:0] word,
  output logic              pend,
  output logic              strobe
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word   <= '0;
      pend   <= 1'b0;
      strobe <= 1'b0;
    end else begin
      pend   <= upd && la_live(code);
      strobe <= pend;
      if (upd) word <= la_pick(code, srcs);
    end
  end
endmodule

// File: rtl/diag_route_top.sv
module diag_route_top
  import diag_route_pkg::*;
#(
  parameter int PERIOD = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] ctrl_reg,
  input  logic [15:0] filt1_word,
  input  logic [15:0] filt2_word,
  input  logic [15:0] test_word,
  input  logic [15:0] adc_word,
  input  logic [15:0] status_word,
  output logic [15:0] dac1_word,
  output logic [15:0] dac2_word,
  output logic        dac1_load,
  output logic        dac2_load,
  output logic [15:0] la_word,
  output logic        la_strobe
);
  localparam int LA_LSB = NUM_DAC * SEL_W;

  diag_src_t         src_bus;
  logic              upd_tick;
  logic              la_pend;
  logic [WORD_W-1:0] dac_words [NUM_DAC];
  logic [NUM_DAC-1:0] dac_loads;

  assign src_bus = '{f1: filt1_word, f2: filt2_word, tst: test_word,
                     adc: adc_word, stat: status_word};

  diag_pacer #(.PERIOD(PERIOD)) u_pacer (
    .clk(clk), .rst_n(rst_n), .tick(upd_tick)
  );

  for (genvar g = 0; g < NUM_DAC; g++) begin : g_dac
    diag_dac_lane u_lane (
      .clk(clk), .rst_n(rst_n), .upd(upd_tick),
      .code(ctrl_reg[g*SEL_W +: SEL_W]), .srcs(src_bus),
      .word(dac_words[g]), .load(dac_loads[g])
    );
  end

  diag_la_lane u_la (
    .clk(clk), .rst_n(rst_n), .upd(upd_tick),
    .code(ctrl_reg[LA_LSB +: SEL_W]), .srcs(src_bus),
    .word(la_word), .pend(la_pend), .strobe(la_strobe)
  );

  assign dac1_word = dac_words[0];
  assign dac2_word = dac_words[1];
  assign dac1_load = dac_loads[0];
  assign dac2_load = dac_loads[1];
endmodule

// File: rtl/diag_route_checker.sv
module diag_route_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        upd_tick,
  input logic        la_pend,
  input logic [15:0] ctrl_reg,
  input logic [15:0] dac1_word,
  input logic [15:0] dac2_word,
  input logic        dac1_load,
  input logic        dac2_load,
  input logic [15:0] la_word,
  input logic        la_strobe
);
  AST_LOAD_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    dac1_load == dac2_load); // R7
  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dac1_load |=> !dac1_load); // R7
  AST_LOAD_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    upd_tick |=> dac1_load); // R7
  AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_tick |=> ($stable(dac1_word) && $stable(dac2_word) && $stable(la_word))); // R9
  AST_STROBE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    la_strobe |-> $past(dac1_load)); // R8
  AST_STROBE_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    la_pend |=> la_strobe); // R8
  AST_RESERVED_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (dac1_load && ($past(ctrl_reg[3:0]) > 4'd4)) |-> (dac1_word == 16'h8000)); // R4
  AST_LA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (dac1_load && (($past(ctrl_reg[11:8]) == 4'd0) || ($past(ctrl_reg[11:8]) > 4'd5)))
      |-> (la_word == 16'h0000)); // R6
endmodule

bind diag_route_top diag_route_checker u_chk (
  .clk(clk), .rst_n(rst_n), .upd_tick(upd_tick), .la_pend(la_pend),
  .ctrl_reg(ctrl_reg), .dac1_word(dac1_word), .dac2_word(dac2_word),
  .dac1_load(dac1_load), .dac2_load(dac2_load),
  .la_word(la_word), .la_strobe(la_strobe)
);

// File: tb/diag_route_top_bench.sv
module diag_route_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ctrl_reg = '0;
  logic [15:0] filt1_word = 16'h1111, filt2_word = 16'h2222, test_word = 16'h3333;
  logic [15:0] adc_word = 16'h4444, status_word = 16'h5555;
  logic [15:0] dac1_word, dac2_word, la_word;
  logic        dac1_load, dac2_load, la_strobe;
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  diag_route_top u_diag_route_top (.*);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_dac(logic [3:0] c);
    if (c == 0) return filt1_word;
    if (c == 1) return filt2_word;
    if (c == 2) return test_word;
    if (c == 3 || c == 4) return adc_word;
    return 16'h8000;
  endfunction

  function automatic logic [15:0] exp_la(logic [3:0] c);
    if (c == 1 || c == 2) return adc_word;
    if (c == 3) return filt1_word;
    if (c == 4) return filt2_word;
    if (c == 5) return status_word;
    return 16'h0000;
  endfunction

  task automatic sync_load();
    @(negedge clk);
    while (!dac1_load) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 dac1", dac1_word, 16'h8000);
    chk("R1 dac2", dac2_word, 16'h8000);
    chk("R1 loads", {14'd0, dac1_load, dac2_load}, 16'd0);
    chk("R1 la", la_word, 16'h0000);
    chk("R1 strobe", {15'd0, la_strobe}, 16'd0);
  endtask

  task automatic t_first_and_period();
    int n;
    rst_n = 1'b1;
    n = 0;
    @(negedge clk); n++;
    while (!dac1_load) begin @(negedge clk); n++; end
    chk("R7 first strobe delay", 16'(n), 16'd128);
    n = 0;
    @(negedge clk); n++;
    chk("R7 load width", {15'd0, dac1_load}, 16'd0);
    while (!dac1_load) begin @(negedge clk); n++; end
    chk("R7 period", 16'(n), 16'd128);
    chk("R7 dac2 load together", {15'd0, dac2_load}, 16'd1);
  endtask

  task automatic t_maps();
    for (int c = 0; c < 16; c++) begin
      ctrl_reg = {4'h0, 4'(c), 4'(15 - c), 4'(c)};
      sync_load();
      chk("R2 dac1 map", dac1_word, exp_dac(4'(c)));
      chk("R3 dac2 map", dac2_word, exp_dac(4'(15 - c)));
      if (c > 4) chk("R4 reserved dac1", dac1_word, 16'h8000);
      chk("R5/R6 la map", la_word, exp_la(4'(c)));
      chk("R8 no strobe with load", {15'd0, la_strobe}, 16'd0);
      @(negedge clk);
      chk("R8 R6 la strobe", {15'd0, la_strobe}, {15'd0, (c >= 1 && c <= 5)});
      @(negedge clk);
      chk("R8 strobe width", {15'd0, la_strobe}, 16'd0);
    end
  endtask

  task automatic t_boundary();
    ctrl_reg = 16'h0300;
    sync_load();
    repeat (5) @(negedge clk);
    ctrl_reg = 16'h0512;
    filt1_word = 16'hABCD;
    repeat (60) @(negedge clk);
    chk("R9 dac1 held", dac1_word, 16'h1111);
    chk("R9 dac2 held", dac2_word, 16'h1111);
    chk("R9 la held", la_word, 16'h1111);
    sync_load();
    chk("R9 dac1 new", dac1_word, 16'h3333);
    chk("R9 dac2 new", dac2_word, 16'h2222);
    chk("R9 la new", la_word, 16'h5555);
    filt1_word = 16'h1111;
  endtask

  task automatic t_upper();
    ctrl_reg = 16'hF421;
    sync_load();
    chk("R10 dac1", dac1_word, filt2_word);
    chk("R10 dac2", dac2_word, test_word);
    chk("R10 la", la_word, filt2_word);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_first_and_period();
    t_maps();
    t_boundary();
    t_upper();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule